// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter and Vector Generator

This block gathers one reset request and a set of interrupt request lines from the processor core and its peripherals. It ranks them in a fixed order and works out the 16-bit vector fetch address of the winner. The processor sees a single request line. When it takes the request, it raises an acknowledge, and the block captures the winning vector and source number. These stay on the outputs until the next acknowledge.

The reset request and the software interrupt cannot be masked. Every other source is gated by the processor's global mask bit. Per-peripheral enables are assumed to be applied before the request lines reach this block. Sources are numbered in priority order, with 0 highest. Source k fetches its vector at 0xFFFE minus 2k. The timer group has five lines and the serial-peripheral group has two. Within a group, the lower-numbered line wins and gets the higher address.

Top module: `irq_arb_top`

## Requirements
- R1: The reset request is source 0 with vector 0xFFFE. It wins over every other request and is never blocked by the mask bit.
- R2: The software interrupt is source 1 with vector 0xFFFC. It is not maskable and loses only to reset.
- R3: While `i_mask` is 1, a request on any source numbered 2 or higher has no effect. `irq_out` stays low unless reset or software is pending, and an acknowledge leaves the captured outputs unchanged.
- R4: The external line `irq1_req` is source 2 at 0xFFFA, `pll_req` is source 3 at 0xFFF8 and `dma_req` is source 4 at 0xFFF6, ranked in that order.
- R5: Timer line `tim_req[k]` is source 5+k with vector 0xFFF4-2k, and a lower k wins.
- R6: Serial-peripheral line `spi_req[k]` is source 10+k with vector 0xFFEA-2k, and a lower k wins.
- R7: `sci_req` is source 12 at 0xFFE6, `aux_req[0]` is source 13 at 0xFFE4, `aux_req[1]` is source 14 at 0xFFE2, and `kbd_req` is source 15 at 0xFFE0, the lowest priority.
- R8: `irq_out` is high in the same cycle if and only if at least one unmasked request is pending.
- R9: On a rising clock edge with `ack` and `irq_out` both high, `vec_addr` and `src_id` take the vector and number of the winner at that edge.
- R10: At any other edge, including an acknowledge with nothing pending, `vec_addr` and `src_id` hold their values.
- R11: A synchronous `rst` sets `vec_addr` to 0xFFFE and `src_id` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Reset request, source 0 |
| swi_req | input | 1 | Software interrupt, source 1 |
| irq1_req | input | 1 | External interrupt line, source 2 |
| pll_req | input | 1 | Clock-synthesizer interrupt, source 3 |
| dma_req | input | 1 | DMA interrupt, source 4 |
| tim_req | input | NUM_TIM | Timer lines, sources 5..9 |
| spi_req | input | NUM_SPI | Serial-peripheral lines, sources 10..11 |
| sci_req | input | 1 | Serial-communications interrupt, source 12 |
| aux_req | input | 2 | Spare lines, sources 13..14 |
| kbd_req | input | 1 | Keyboard/second external line, source 15 |
| i_mask | input | 1 | Global mask bit, 1 blocks sources 2..15 |
| ack | input | 1 | Processor acknowledge |
| irq_out | output | 1 | Unmasked request pending |
| vec_addr | output | 16 | Captured vector fetch address |
| src_id | output | 5 | Captured source number |

## Verification
The hardest case to reach is an acknowledge that arrives while several requests pending in different groups sit around the masked/unmasked boundary. In that case the capture must pick exactly the surviving winner, or must hold when nothing survives. Random stimulus sets each line with low probability and toggles the mask and acknowledge independently, so that sparse mixes of neighbours occur often. Directed steps then force all lines high with the mask both set and clear, and issue an acknowledge with nothing pending.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int VEC_W   = 16;
    localparam int ID_W    = 5;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFE;
    // sources below this index ignore the global mask
    localparam int NUM_UNMASK = 2;

    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  id;
        logic [VEC_W-1:0] vec;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [ID_W-1:0] idx);
        return VEC_TOP - {{(VEC_W-ID_W-1){1'b0}}, idx, 1'b0};
    endfunction

endpackage

// File: rtl/irq_gather.sv
module irq_gather
    import irq_arb_pkg::*;
#(
    parameter int NUM_TIM = 5,
    parameter int NUM_SPI = 2,
    parameter int NSRC    = 16
) (
    input  logic               rst_req,
    input  logic               swi_req,
    input  logic               irq1_req,
    input  logic               pll_req,
    input  logic               dma_req,
    input  logic [NUM_TIM-1:0] tim_req,
    input  logic [NUM_SPI-1:0] spi_req,
    input  logic               sci_req,
    input  logic [1:0]         aux_req,
    input  logic               kbd_req,
    input  logic               i_mask,
    output logic [NSRC-1:0]    eff_req
);
    logic [NSRC-1:0] raw;

    assign raw = {kbd_req, aux_req[1], aux_req[0], sci_req,
                  spi_req, tim_req,
                  dma_req, pll_req, irq1_req, swi_req, rst_req};

    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        if (g < NUM_UNMASK) begin : g_nmi
            assign eff_req[g] = raw[g];
        end else begin : g_msk
            assign eff_req[g] = raw[g] & ~i_mask;
        end
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic [NSRC-1:0] eff_req,
    output pick_t           pick
);
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eff_req[i]) begin
                pick.valid = 1'b1;
                pick.id    = ID_W'(i);
                pick.vec   = vec_of(ID_W'(i));
            end
        end
    end

endmodule

// File: rtl/vec_latch.sv
module vec_latch
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  pick_t            pick,
    output logic [VEC_W-1:0] vec_q,
    output logic [ID_W-1:0]  id_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= VEC_TOP;
            id_q  <= '0;
        end else if (ack && pick.valid) begin
            vec_q <= pick.vec;
            id_q  <= pick.id;
        end
    end

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int NUM_TIM = 5,
    parameter int NUM_SPI = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rst_req,
    input  logic               swi_req,
    input  logic               irq1_req,
    input  logic               pll_req,
    input  logic               dma_req,
    input  logic [NUM_TIM-1:0] tim_req,
    input  logic [NUM_SPI-1:0] spi_req,
    input  logic               sci_req,
    input  logic [1:0]         aux_req,
    input  logic               kbd_req,
    input  logic               i_mask,
    input  logic               ack,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_addr,
    output logic [ID_W-1:0]    src_id
);
    localparam int NSRC = 5 + NUM_TIM + NUM_SPI + 4;

    logic [NSRC-1:0] eff_req;
    pick_t           pick;

    irq_gather #(.NUM_TIM(NUM_TIM), .NUM_SPI(NUM_SPI), .NSRC(NSRC)) u_gather (
        .rst_req(rst_req), .swi_req(swi_req), .irq1_req(irq1_req),
        .pll_req(pll_req), .dma_req(dma_req), .tim_req(tim_req),
        .spi_req(spi_req), .sci_req(sci_req), .aux_req(aux_req),
        .kbd_req(kbd_req), .i_mask(i_mask), .eff_req(eff_req)
    );

    prio_pick #(.NSRC(NSRC)) u_pick (
        .eff_req(eff_req),
        .pick(pick)
    );

    vec_latch u_latch (
        .clk(clk), .rst(rst), .ack(ack), .pick(pick),
        .vec_q(vec_addr), .id_q(src_id)
    );

    assign irq_out = pick.valid;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_TIM = 5,
    parameter int NUM_SPI = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               rst_req,
    input logic               swi_req,
    input logic               irq1_req,
    input logic               pll_req,
    input logic               dma_req,
    input logic [NUM_TIM-1:0] tim_req,
    input logic [NUM_SPI-1:0] spi_req,
    input logic               sci_req,
    input logic [1:0]         aux_req,
    input logic               kbd_req,
    input logic               i_mask,
    input logic               ack,
    input logic               irq_out,
    input logic [VEC_W-1:0]   vec_addr,
    input logic [ID_W-1:0]    src_id
);
    logic any_maskable;
    assign any_maskable = irq1_req | pll_req | dma_req | (|tim_req) |
                          (|spi_req) | sci_req | (|aux_req) | kbd_req;

    // R1
    reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && rst_req) |=> (vec_addr == 16'hFFFE && src_id == '0));

    // R2
    swi_second_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && swi_req && !rst_req) |=> (vec_addr == 16'hFFFC && src_id == ID_W'(1)));

    // R3
    mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (i_mask && !rst_req && !swi_req) |-> !irq_out);

    // R8
    irq_line_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == (rst_req || swi_req || (!i_mask && any_maskable)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ack && irq_out) |=> ($stable(vec_addr) && $stable(src_id)));

endmodule

bind irq_arb_top irq_arb_chk #(.NUM_TIM(NUM_TIM), .NUM_SPI(NUM_SPI)) u_chk (
    .clk(clk), .rst(rst), .rst_req(rst_req), .swi_req(swi_req),
    .irq1_req(irq1_req), .pll_req(pll_req), .dma_req(dma_req),
    .tim_req(tim_req), .spi_req(spi_req), .sci_req(sci_req),
    .aux_req(aux_req), .kbd_req(kbd_req), .i_mask(i_mask), .ack(ack),
    .irq_out(irq_out), .vec_addr(vec_addr), .src_id(src_id)
);

// File: tb/test_irq_arb_top.sv
module test_irq_arb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] req;
    logic        i_mask;
    logic        ack;
    logic        irq_out;
    logic [15:0] vec_addr;
    logic [4:0]  src_id;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] exp_vec;
    logic [4:0]  exp_id;

    always #5 clk = ~clk;

    irq_arb_top i_irq_arb_top (
        .clk(clk), .rst(rst),
        .rst_req(req[0]), .swi_req(req[1]), .irq1_req(req[2]),
        .pll_req(req[3]), .dma_req(req[4]), .tim_req(req[9:5]),
        .spi_req(req[11:10]), .sci_req(req[12]), .aux_req(req[14:13]),
        .kbd_req(req[15]), .i_mask(i_mask), .ack(ack),
        .irq_out(irq_out), .vec_addr(vec_addr), .src_id(src_id)
    );

    function automatic logic [15:0] eff_of(input logic [15:0] r, input logic m);
        return m ? (r & 16'h0003) : r;
    endfunction

    function automatic int winner(input logic [15:0] r, input logic m);
        logic [15:0] e = eff_of(r, m);
        for (int i = 0; i < 16; i++) if (e[i]) return i;
        return -1;
    endfunction

    function automatic string tag_of(input int idx);
        if (idx == 0) return "R1";
        if (idx == 1) return "R2";
        if (idx <= 4) return "R4";
        if (idx <= 9) return "R5";
        if (idx <= 11) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // drive at negedge, check irq_out, clock, check captured outputs
    task automatic step(input logic [15:0] r, input logic m, input logic a, input string tag);
        int w;
        @(negedge clk);
        req = r; i_mask = m; ack = a;
        #1;
        w = winner(r, m);
        check({tag, "/R8"}, 32'(irq_out), 32'(w >= 0));
        @(posedge clk);
        if (a && w >= 0) begin
            exp_id  = 5'(w);
            exp_vec = 16'hFFFE - 16'(2 * w);
        end
        #1;
        check({tag, "/R9"}, 32'(vec_addr), 32'(exp_vec));
        check({tag, "/R10"}, 32'(src_id), 32'(exp_id));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; req = '0; i_mask = 1'b0; ack = 1'b0;
        exp_vec = 16'hFFFE; exp_id = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11", 32'(vec_addr), 32'h0000FFFE);
        check("R11", 32'(src_id), 32'd0);
        rst = 1'b0;

        // R1 everything pending, masked and unmasked
        step(16'hFFFF, 1'b0, 1'b1, "R1");
        step(16'hFFFF, 1'b1, 1'b1, "R1");
        // R2 software over all maskable
        step(16'hFFFE, 1'b0, 1'b1, "R2");
        step(16'h0002, 1'b1, 1'b1, "R2");
        // R3 only maskable, mask set: no line, acknowledge ignored
        step(16'hFFFC, 1'b1, 1'b1, "R3");
        // R4 order
        step(16'h001C, 1'b0, 1'b1, "R4");
        step(16'h0018, 1'b0, 1'b1, "R4");
        step(16'h0010, 1'b0, 1'b1, "R4");
        // R5 timer lines
        step(16'h03E0, 1'b0, 1'b1, "R5");
        step(16'h0300, 1'b0, 1'b1, "R5");
        step(16'h0200, 1'b0, 1'b1, "R5");
        // R6 serial-peripheral lines
        step(16'h0C00, 1'b0, 1'b1, "R6");
        step(16'h0800, 1'b0, 1'b1, "R6");
        // R7 low groups
        step(16'hF000, 1'b0, 1'b1, "R7");
        step(16'hE000, 1'b0, 1'b1, "R7");
        step(16'hC000, 1'b0, 1'b1, "R7");
        step(16'h8000, 1'b0, 1'b1, "R7");
        // R10 ack with nothing pending, and pending without ack
        step(16'h0000, 1'b0, 1'b1, "R10");
        step(16'h0004, 1'b0, 1'b0, "R10");

        for (int n = 0; n < 600; n++) begin
            logic [15:0] r;
            logic        m;
            logic        a;
            for (int b = 0; b < 16; b++) r[b] = ($urandom % 8) == 0;
            if (($urandom % 4) != 0) r[1:0] = 2'b00;
            m = $urandom % 3 == 0;
            a = $urandom % 2 == 1;
            step(r, m, a, tag_of(winner(r, m) < 0 ? 15 : winner(r, m)));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule